// File: doc/BRIEF.md
# Prescaled Triangle Period Counter

This block is a 16-bit timer counter that runs in triangle (up/down) fashion between zero and a programmable period value. A clock-enable prescaler slows the count: a 4-bit code selects a power-of-two division of the system clock. Once started, the counter climbs from zero to the period value and then turns around. It falls back to zero and turns around again, with no end.

Compare units elsewhere on the chip read the count and the direction output. Both change together at every turning point. The counter marks each arrival at the peak and at zero with a one-cycle strobe and a sticky flag. A flag is cleared by writing 0 to it, and each flag can request an interrupt. Software can halt and resume the count, reset it to its start state, or load a count value directly. The period register either takes new values at once or holds them in a shadow until the next zero arrival, so a running waveform never sees a half-finished cycle.

Top module: `updown_period_timer`

## Requirements
- R1: After reset the count is 0x0000 and the direction is up (`count_up` = 1). Both flags are 0 and the active period is 0xFFFF.
- R2: Each advance moves the count by one in its current direction. When the count reaches the active period while counting up, `count_up` goes low in that same cycle and `peak_evt` pulses for one cycle. The count then falls by one per advance.
- R3: When the count returns to 0x0000 while counting down, `zero_evt` pulses for one cycle and `count_up` goes high in that same cycle. Leaving 0x0000 at start-up produces no zero event.
- R4: Prescaler code n gives one advance per 2^n clocks while running, so code 0010 divides by 4. After a soft clear, the first advance happens on the 2^n-th clock edge with `stop` low.
- R5: While `stop` = 1, the count and direction hold. Clearing `stop` resumes counting from the held state.
- R6: A soft-clear pulse sets the count to 0x0000 and the direction to up, and restarts the prescaler. A period value waiting in the shadow becomes active at the same edge.
- R7: A `cnt_wr` pulse loads `cnt_wdata` into the count on the next edge and leaves the direction unchanged. Soft clear wins over a count write, and a count write wins over an advance.
- R8: `zero_flag` and `peak_flag` set on their events and stay set. A `flag_wr` pulse clears a flag whose write bit is 0 and leaves alone a flag whose write bit is 1. An event in the same cycle as a clear leaves the flag set.
- R9: `zero_irq` is high exactly when `zero_flag` and `zero_ie` are both 1. `peak_irq` behaves the same way with `peak_flag` and `peak_ie`.
- R10: With `per_buf_en` = 0, a period write changes `period_active` on the next edge. With `per_buf_en` = 1, the written value waits and becomes active at the edge that produces the next zero event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 4 | Prescaler code n, divide by 2^n |
| stop | input | 1 | 1 halts counting, 0 runs |
| soft_clr | input | 1 | Pulse: return count to start state |
| cnt_wr | input | 1 | Pulse: load count value |
| cnt_wdata | input | 16 | Count value to load |
| per_wr | input | 1 | Pulse: write period value |
| per_wdata | input | 16 | Period value to write |
| per_buf_en | input | 1 | 1 routes period writes through the shadow |
| zero_ie | input | 1 | Zero interrupt enable |
| peak_ie | input | 1 | Peak interrupt enable |
| flag_wr | input | 1 | Pulse: flag write |
| zero_flag_wdata | input | 1 | Zero flag write bit (0 clears) |
| peak_flag_wdata | input | 1 | Peak flag write bit (0 clears) |
| count | output | 16 | Current count |
| count_up | output | 1 | 1 counting up, 0 counting down |
| period_active | output | 16 | Period value in use |
| zero_evt | output | 1 | One-cycle zero arrival strobe |
| peak_evt | output | 1 | One-cycle peak arrival strobe |
| zero_flag | output | 1 | Sticky zero flag |
| peak_flag | output | 1 | Sticky peak flag |
| zero_irq | output | 1 | Zero interrupt request |
| peak_irq | output | 1 | Peak interrupt request |

## Verification
The bench checks two full triangle cycles edge by edge. A design that reversed one step late would show the period plus one at the top or wrap below zero. A design that raised a zero event on leaving zero at start-up would pulse `zero_evt` at the first step. A prescaler test counts the exact edge of the first advance under divide-by-4, which catches an off-by-one in the division. The buffered-period test samples the edge just before and the edge of the zero arrival. A design that applied the write at once, or one cycle late, shows the wrong period at one of those two samples. The flag tests write 1 to a set flag and clear one flag while keeping the other set. A design that treated the write bit as a set, or cleared both flags, fails there.

// File: rtl/udt_pkg.sv
package udt_pkg;

    localparam int CNT_W = 16;
    localparam int PRE_W = 16;
    localparam int DIV_W = 4;
    localparam logic [CNT_W-1:0] PERIOD_RST = '1;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             up;
    } tri_state_t;

    typedef struct packed {
        tri_state_t st;
        logic       peak;
        logic       zero;
    } tri_step_t;

    // One advance of the triangle counter against the given period.
    function automatic tri_step_t tri_step(input tri_state_t s,
                                           input logic [CNT_W-1:0] per);
        tri_step_t  r;
        logic [CNT_W:0] inc;
        r      = '0;
        r.st   = s;
        inc    = {1'b0, s.value} + {{CNT_W{1'b0}}, 1'b1};
        if (s.up) begin
            if (inc >= {1'b0, per}) begin
                r.st.value = per;
                r.st.up    = 1'b0;
                r.peak     = 1'b1;
            end else begin
                r.st.value = inc[CNT_W-1:0];
            end
        end else begin
            if (s.value <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
                r.st.value = '0;
                r.st.up    = 1'b1;
                r.zero     = 1'b1;
            end else begin
                r.st.value = s.value - {{(CNT_W-1){1'b0}}, 1'b1};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/udt_prescaler.sv
module udt_prescaler #(
    parameter int PRE_W = udt_pkg::PRE_W,
    parameter int DIV_W = udt_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] code,
    output logic             tick
);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = (ONE << code) - ONE;
        tick = run && !clr && (cnt == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + ONE;
        end
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(tick) && $past(run) && $stable(code) && (mask != '0)) |-> !tick);

endmodule

// File: rtl/udt_period_reg.sv
module udt_period_reg #(
    parameter int               W       = udt_pkg::CNT_W,
    parameter logic [W-1:0]     RST_VAL = udt_pkg::PERIOD_RST
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         buf_en,
    input  logic         zero_hit,
    input  logic         sclr,
    output logic [W-1:0] period
);
    logic [W-1:0] shadow;
    logic         pend;
    logic         xfer;

    assign xfer = pend && (zero_hit || sclr);

    always_ff @(posedge clk) begin
        if (rst) begin
            period <= RST_VAL;
            shadow <= RST_VAL;
            pend   <= 1'b0;
        end else if (wr && !buf_en) begin
            period <= wdata;
            pend   <= 1'b0;
        end else begin
            if (xfer) begin
                period <= shadow;
                pend   <= 1'b0;
            end
            if (wr) begin
                shadow <= wdata;
                pend   <= 1'b1;
            end
        end
    end

    // R10
    per_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (period != $past(period)) |->
            ($past(wr && !buf_en) || $past(zero_hit) || $past(sclr)));

endmodule

// File: rtl/udt_tri_counter.sv
module udt_tri_counter
    import udt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             sclr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output tri_state_t       state,
    output logic             peak_hit,
    output logic             zero_hit,
    output logic             peak_evt,
    output logic             zero_evt
);
    tri_step_t nxt;
    logic      adv;

    always_comb begin
        nxt      = tri_step(state, period);
        adv      = tick && !sclr && !load;
        peak_hit = adv && nxt.peak;
        zero_hit = adv && nxt.zero;
    end

    always_ff @(posedge clk) begin
        if (rst || sclr) begin
            state.value <= '0;
            state.up    <= 1'b1;
            peak_evt    <= 1'b0;
            zero_evt    <= 1'b0;
        end else if (load) begin
            state.value <= load_val;
            peak_evt    <= 1'b0;
            zero_evt    <= 1'b0;
        end else if (tick) begin
            state    <= nxt.st;
            peak_evt <= nxt.peak;
            zero_evt <= nxt.zero;
        end else begin
            peak_evt <= 1'b0;
            zero_evt <= 1'b0;
        end
    end

    // R3
    zero_evt_chk: assert property (@(posedge clk) disable iff (rst)
        zero_evt |-> !$past(state.up));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick) && !$past(sclr) && !$past(load)) |-> $stable(state));

endmodule

// File: rtl/udt_event_flag.sv
module udt_event_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic wr,
    input  logic wbit,
    input  logic ie,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (wr && !wbit) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && ie;

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !wbit && !hit) |=> !flag);

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);

endmodule

// File: rtl/updown_period_timer.sv
module updown_period_timer
    import udt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] div_code,
    input  logic          stop,
    input  logic          soft_clr,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          per_wr,
    input  logic [CW-1:0] per_wdata,
    input  logic          per_buf_en,
    input  logic          zero_ie,
    input  logic          peak_ie,
    input  logic          flag_wr,
    input  logic          zero_flag_wdata,
    input  logic          peak_flag_wdata,
    output logic [CW-1:0] count,
    output logic          count_up,
    output logic [CW-1:0] period_active,
    output logic          zero_evt,
    output logic          peak_evt,
    output logic          zero_flag,
    output logic          peak_flag,
    output logic          zero_irq,
    output logic          peak_irq
);
    localparam int NEV = 2;   // index 0 zero, index 1 peak

    logic       tick;
    logic       zero_hit, peak_hit;
    tri_state_t st;

    udt_prescaler #(.PRE_W(PRE_W), .DIV_W(DW)) u_pre (
        .clk(clk), .rst(rst), .run(!stop), .clr(soft_clr),
        .code(div_code), .tick(tick)
    );

    udt_period_reg #(.W(CW), .RST_VAL(PERIOD_RST)) u_per (
        .clk(clk), .rst(rst), .wr(per_wr), .wdata(per_wdata),
        .buf_en(per_buf_en), .zero_hit(zero_hit), .sclr(soft_clr),
        .period(period_active)
    );

    udt_tri_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .sclr(soft_clr),
        .load(cnt_wr), .load_val(cnt_wdata), .period(period_active),
        .state(st), .peak_hit(peak_hit), .zero_hit(zero_hit),
        .peak_evt(peak_evt), .zero_evt(zero_evt)
    );

    assign count    = st.value;
    assign count_up = st.up;

    logic [NEV-1:0] hit_v, wbit_v, ie_v, flag_v, irq_v;
    assign hit_v  = {peak_hit, zero_hit};
    assign wbit_v = {peak_flag_wdata, zero_flag_wdata};
    assign ie_v   = {peak_ie, zero_ie};

    for (genvar g = 0; g < NEV; g++) begin : g_flag
        udt_event_flag u_flag (
            .clk(clk), .rst(rst), .hit(hit_v[g]), .wr(flag_wr),
            .wbit(wbit_v[g]), .ie(ie_v[g]), .flag(flag_v[g]), .irq(irq_v[g])
        );
    end

    assign zero_flag = flag_v[0];
    assign peak_flag = flag_v[1];
    assign zero_irq  = irq_v[0];
    assign peak_irq  = irq_v[1];

    // R2
    dir_peak_chk: assert property (@(posedge clk) disable iff (rst)
        (!count_up && $past(count_up) && !$past(soft_clr)) |-> peak_evt);

endmodule

// File: tb/sim_updown_period_timer.sv
module sim_updown_period_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  div_code = '0;
    logic        stop = 1'b1, soft_clr = 1'b0, cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0, per_wdata = '0;
    logic        per_wr = 1'b0, per_buf_en = 1'b0, zero_ie = 1'b0, peak_ie = 1'b0;
    logic        flag_wr = 1'b0, zero_flag_wdata = 1'b1, peak_flag_wdata = 1'b1;
    logic [15:0] count, period_active;
    logic        count_up, zero_evt, peak_evt, zero_flag, peak_flag, zero_irq, peak_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updown_period_timer u0 (
        .clk(clk), .rst(rst), .div_code(div_code), .stop(stop), .soft_clr(soft_clr),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .per_wr(per_wr), .per_wdata(per_wdata),
        .per_buf_en(per_buf_en), .zero_ie(zero_ie), .peak_ie(peak_ie), .flag_wr(flag_wr),
        .zero_flag_wdata(zero_flag_wdata), .peak_flag_wdata(peak_flag_wdata),
        .count(count), .count_up(count_up), .period_active(period_active),
        .zero_evt(zero_evt), .peak_evt(peak_evt), .zero_flag(zero_flag),
        .peak_flag(peak_flag), .zero_irq(zero_irq), .peak_irq(peak_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_sclr();
        soft_clr = 1'b1; step(1); soft_clr = 1'b0;
    endtask

    task automatic write_period(input logic [15:0] v);
        per_wdata = v; per_wr = 1'b1; step(1); per_wr = 1'b0;
    endtask

    function automatic int tri_val(input int k, input int p);
        int m;
        m = k % (2 * p);
        return (m <= p) ? m : 2 * p - m;
    endfunction

    task automatic t_reset();
        chk(count == 16'h0, "R1", "count", count, 0);
        chk(count_up == 1'b1, "R1", "dir", count_up, 1);
        chk(!zero_flag && !peak_flag, "R1", "flags", {zero_flag, peak_flag}, 0);
        chk(period_active == 16'hFFFF, "R1", "period", period_active, 16'hFFFF);
    endtask

    // R2, R3: two triangle cycles with period 4
    task automatic t_triangle();
        bit ok_v = 1, ok_d = 1, ok_p = 1, ok_z = 1;
        int bad = 0;
        logic [31:0] bad_act = 0, bad_exp = 0;
        stop = 1'b1; div_code = 4'd0; per_buf_en = 1'b0;
        write_period(16'd4);
        do_sclr();
        stop = 1'b0;
        for (int k = 1; k <= 16; k++) begin
            int m;
            step(1);
            m = k % 8;
            if (count != 16'(tri_val(k, 4))) begin
                ok_v = 0; bad = k; bad_act = count; bad_exp = tri_val(k, 4);
            end
            if (count_up != ((m == 0) || (m < 4))) ok_d = 0;
            if (peak_evt != (m == 4)) ok_p = 0;
            if (zero_evt != (m == 0)) ok_z = 0;
        end
        stop = 1'b1;
        chk(ok_v, "R2", $sformatf("count at step %0d", bad), bad_act, bad_exp);
        chk(ok_d, "R2", "direction follows triangle", ok_d, 1);
        chk(ok_p, "R2", "peak strobe only at period", ok_p, 1);
        chk(ok_z, "R3", "zero strobe only on return, not at start", ok_z, 1);
    endtask

    // R8, R9: flags from the triangle run, counter stopped
    task automatic t_flags();
        chk(zero_flag && peak_flag, "R8", "flags set", {zero_flag, peak_flag}, 2'b11);
        zero_ie = 1'b0; peak_ie = 1'b0; step(1);
        chk(!zero_irq && !peak_irq, "R9", "irq masked", {zero_irq, peak_irq}, 0);
        zero_ie = 1'b1; peak_ie = 1'b1; step(1);
        chk(zero_irq && peak_irq, "R9", "irq enabled", {zero_irq, peak_irq}, 2'b11);
        zero_flag_wdata = 1'b1; peak_flag_wdata = 1'b1; flag_wr = 1'b1; step(1); flag_wr = 1'b0;
        chk(zero_flag && peak_flag, "R8", "write 1 no effect", {zero_flag, peak_flag}, 2'b11);
        zero_flag_wdata = 1'b0; flag_wr = 1'b1; step(1); flag_wr = 1'b0;
        chk(!zero_flag && peak_flag, "R8", "clear zero only", {zero_flag, peak_flag}, 2'b01);
        peak_flag_wdata = 1'b0; zero_flag_wdata = 1'b1; flag_wr = 1'b1; step(1); flag_wr = 1'b0;
        peak_flag_wdata = 1'b1;
        chk(!peak_flag && !peak_irq, "R8", "clear peak", {peak_flag, peak_irq}, 0);
        zero_ie = 1'b0; peak_ie = 1'b0;
    endtask

    // R4: divide by 4
    task automatic t_prescale();
        stop = 1'b1; write_period(16'd100); div_code = 4'b0010;
        do_sclr();
        stop = 1'b0;
        step(3);
        chk(count == 16'd0, "R4", "no advance after 3 clocks", count, 0);
        step(1);
        chk(count == 16'd1, "R4", "advance on 4th clock", count, 1);
        step(4);
        chk(count == 16'd2, "R4", "second advance at 8", count, 2);
        stop = 1'b1; div_code = 4'd0;
    endtask

    // R5: stop holds
    task automatic t_stop();
        write_period(16'd4); do_sclr();
        stop = 1'b0; step(2); stop = 1'b1;
        step(5);
        chk(count == 16'd2 && count_up, "R5", "held while stopped", count, 2);
        stop = 1'b0; step(1); stop = 1'b1;
        chk(count == 16'd3, "R5", "resume", count, 3);
    endtask

    // R7, R6
    task automatic t_write_clear();
        cnt_wdata = 16'h0003; cnt_wr = 1'b1; step(1); cnt_wr = 1'b0;
        chk(count == 16'h0003 && count_up, "R7", "count load keeps dir", count, 3);
        stop = 1'b0; step(1); stop = 1'b1;
        chk(count == 16'h0004 && !count_up, "R7", "continue from loaded", count, 4);
        cnt_wdata = 16'h0002; cnt_wr = 1'b1; stop = 1'b0; step(1); cnt_wr = 1'b0; stop = 1'b1;
        chk(count == 16'h0002 && !count_up, "R7", "load wins over advance", count, 2);
        cnt_wdata = 16'h0009; cnt_wr = 1'b1; soft_clr = 1'b1; step(1);
        cnt_wr = 1'b0; soft_clr = 1'b0;
        chk(count == 16'h0000 && count_up, "R6", "soft clear wins", count, 0);
        per_buf_en = 1'b1; write_period(16'd9);
        chk(period_active == 16'd4, "R10", "buffered not immediate", period_active, 4);
        do_sclr();
        chk(period_active == 16'd9, "R6", "soft clear loads shadow", period_active, 9);
        per_buf_en = 1'b0; write_period(16'd4);
        chk(period_active == 16'd4, "R10", "unbuffered immediate", period_active, 4);
    endtask

    // R10: buffered write applied at zero arrival
    task automatic t_buffer();
        do_sclr();
        per_buf_en = 1'b1; write_period(16'd6);
        stop = 1'b0;
        step(7);
        chk(period_active == 16'd4 && count == 16'd1, "R10", "old period before zero",
            period_active, 4);
        step(1);
        chk(period_active == 16'd6 && zero_evt, "R10", "new period at zero", period_active, 6);
        step(6);
        chk(count == 16'd6 && peak_evt, "R10", "peak at new period", count, 6);
        stop = 1'b1; per_buf_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_triangle();
        t_flags();
        t_prescale();
        t_stop();
        t_write_clear();
        t_buffer();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule